// File: doc/BRIEF.md
# Quad-Lane Bidirectional Serial-to-Parallel Driver

This block converts four serial bit streams into 32 parallel outputs. It has four independent 8-stage shift chains (lanes 0 to 3) that share one clock. On every rising edge where the chip is selected, each lane takes one bit from its own serial input, so four bits enter per clock. A direction input sets which end of each chain the new bit enters and which end feeds the lane's serial output. The serial outputs let further devices be cascaded behind this one.

A level-sensitive latch enable passes the chain contents to the parallel outputs while it is high. While it is low, the outputs keep the last captured value and the chains go on shifting underneath. Between the latch and the pins, a per-lane blanking input can force a lane to its inactive level, and a polarity input can then invert all 32 outputs. The block is meant to feed wide output drivers, such as display column drivers, from a narrow serial link.

Top module: `quad_s2p_driver`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every chain stage and the held latch value clear to 0. With `latch_en`, `invert` and `blank` all 0, `par_out` and `ser_out` then read 0.
- R2: On one rising edge, each lane takes its own `ser_in[k]` bit, with no influence from the other lanes' inputs.
- R3: With `shift_dir` = 1 (forward) and `chip_sel` = 1, each edge moves stage s to stage s+1 and loads `ser_in[k]` into stage 1. `ser_out[k]` shows stage 8.
- R4: With `shift_dir` = 0 (reverse) and `chip_sel` = 1, each edge moves stage s to stage s-1 and loads `ser_in[k]` into stage 8. `ser_out[k]` shows stage 1.
- R5: With `chip_sel` = 0, the chains keep their contents across clock edges whatever `ser_in` carries.
- R6: While `latch_en` is 1, the latched view follows the chain contents in the same cycle. Each edge sampled with `latch_en` = 1 stores the updated chain contents as the held value.
- R7: While `latch_en` is 0, the latched view keeps the held value, and the chains still shift as R3 and R4 describe.
- R8: `blank[k]` = 1 forces the 8 outputs of lane k to 0 before any inversion. The other lanes are not affected.
- R9: `invert` = 1 inverts all 32 outputs after blanking, so a blanked lane reads all ones.
- R10: Bit `8*k + s - 1` of `par_out` carries stage s (1 to 8) of lane k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifting takes place on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel | input | 1 | 1 allows shifting; 0 freezes the chains |
| shift_dir | input | 1 | 1 = forward (stage 1 toward 8), 0 = reverse |
| latch_en | input | 1 | 1 = latch transparent, 0 = hold |
| invert | input | 1 | 1 inverts all parallel outputs after blanking |
| blank | input | 4 | Per-lane blanking, bit k blanks lane k |
| ser_in | input | 4 | Serial data in, bit k for lane k |
| ser_out | output | 4 | Serial cascade out, bit k from lane k |
| par_out | output | 32 | Conditioned parallel outputs, lane-major |

## Verification
The hardest state to reach from the ports is a latch holding one frame while the chains already carry a different one, with blanking and inversion changing on top of it. Only the held frame may show on the outputs, and the new frame must appear on the first cycle the latch opens. The stimulus loads a frame with the latch open and then closes it. It shifts new random data in both directions while toggling the blanking and polarity inputs, and finally reopens the latch. A behavioural model in the bench is compared against the outputs on every cycle through this sequence. A reset in the middle of shifting and a spell with the chip deselected are also run, to show that the chains clear and freeze.

// File: rtl/quad_s2p_pkg.sv
// Package: shared sizing defaults and the shift-direction encoding for the
// quad-lane serial-to-parallel driver. Assumes at least two stages per lane.
package quad_s2p_pkg;

    localparam int unsigned LANE_CNT  = 4;
    localparam int unsigned STAGE_CNT = 8;

    // Encoding of the direction pin: 1 moves data from stage 1 toward the last stage.
    typedef enum logic {
        SHIFT_REV = 1'b0,
        SHIFT_FWD = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/s2p_shift_lane.sv
// Module: one bidirectional shift chain. It holds when not selected, loads
// its serial input at the end chosen by the direction, and presents the far
// end as the cascade output. Also exports next-state for the latch stage.
// Assumes: DEPTH >= 2; reset is synchronous and active low.
module s2p_shift_lane
    import quad_s2p_pkg::*;
#(
    parameter int unsigned DEPTH = STAGE_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             dir,
    input  logic             sin,
    output logic [DEPTH-1:0] stages,
    output logic [DEPTH-1:0] stages_nxt,
    output logic             sout
);

    logic [DEPTH-1:0] chain_q;

    // Next-state: hold, forward shift (R3) or reverse shift (R4).
    always_comb begin
        if (!sel) begin
            stages_nxt = chain_q;
        end else if (dir == SHIFT_FWD) begin
            stages_nxt = {chain_q[DEPTH-2:0], sin};
        end else begin
            stages_nxt = {sin, chain_q[DEPTH-1:1]};
        end
    end

    // State register with synchronous clear (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= stages_nxt;
        end
    end

    // Cascade tap taken from the end opposite the input.
    assign sout   = (dir == SHIFT_FWD) ? chain_q[DEPTH-1] : chain_q[0];
    assign stages = chain_q;

endmodule

// File: rtl/s2p_out_latch.sv
// Module: a level-sensitive output latch built from a hold register and a
// bypass. While enabled, the view follows the live chain, and each edge
// stores the chain's next contents. While disabled, the stored copy is shown.
// Assumes: enable is synchronous to clk.
module s2p_out_latch #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] live_nxt,
    output logic [WIDTH-1:0] view
);

    logic [WIDTH-1:0] hold_q;

    // Hold register: tracks the chain while open, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (en) begin
            hold_q <= live_nxt;
        end
    end

    // Transparent path while open, stored copy while closed.
    always_comb begin
        view = en ? live : hold_q;
    end

endmodule

// File: rtl/s2p_out_gate.sv
// Module: output conditioning. Per-lane blanking forces a lane to 0, then
// global polarity inversion applies to every bit. Purely combinational.
// Assumes: the input vector is lane-major, DEPTH bits per lane.
module s2p_out_gate #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned WIDTH = LANES * DEPTH
) (
    input  logic [WIDTH-1:0] lat,
    input  logic [LANES-1:0] blank,
    input  logic             invert,
    output logic [WIDTH-1:0] pout
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DEPTH-1:0] blanked;
        // Blank first (R8), then invert (R9).
        always_comb begin
            blanked = blank[k] ? {DEPTH{1'b0}} : lat[k*DEPTH +: DEPTH];
            pout[k*DEPTH +: DEPTH] = blanked ^ {DEPTH{invert}};
        end
    end

endmodule

// File: rtl/quad_s2p_driver.sv
// Module: top of the quad-lane serial-to-parallel driver. It instantiates one
// shift chain per lane, a shared output latch and the blanking/polarity gate.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module quad_s2p_driver
    import quad_s2p_pkg::*;
#(
    parameter int unsigned LANES = LANE_CNT,
    parameter int unsigned DEPTH = STAGE_CNT,
    localparam int unsigned WIDTH = LANES * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_sel,
    input  logic             shift_dir,
    input  logic             latch_en,
    input  logic             invert,
    input  logic [LANES-1:0] blank,
    input  logic [LANES-1:0] ser_in,
    output logic [LANES-1:0] ser_out,
    output logic [WIDTH-1:0] par_out
);

    logic [WIDTH-1:0] chain_flat;
    logic [WIDTH-1:0] chain_next;
    logic [WIDTH-1:0] lat_flat;

    // One chain per lane; lane k occupies bits k*DEPTH upward (R10).
    for (genvar k = 0; k < LANES; k++) begin : g_chain
        s2p_shift_lane #(
            .DEPTH(DEPTH)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (chip_sel),
            .dir       (shift_dir),
            .sin       (ser_in[k]),
            .stages    (chain_flat[k*DEPTH +: DEPTH]),
            .stages_nxt(chain_next[k*DEPTH +: DEPTH]),
            .sout      (ser_out[k])
        );
    end

    s2p_out_latch #(
        .WIDTH(WIDTH)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (latch_en),
        .live    (chain_flat),
        .live_nxt(chain_next),
        .view    (lat_flat)
    );

    s2p_out_gate #(
        .LANES(LANES),
        .DEPTH(DEPTH)
    ) u_gate (
        .lat   (lat_flat),
        .blank (blank),
        .invert(invert),
        .pout  (par_out)
    );

endmodule

// File: rtl/quad_s2p_driver_chk.sv
// Module: property checker for quad_s2p_driver, attached by bind. It observes
// ports and the internal chain and latch vectors.
// Assumes: the same LANES/DEPTH values as the bound instance.
module quad_s2p_driver_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned WIDTH = LANES * DEPTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_sel,
    input logic             shift_dir,
    input logic             latch_en,
    input logic             invert,
    input logic [LANES-1:0] blank,
    input logic [LANES-1:0] ser_in,
    input logic [LANES-1:0] ser_out,
    input logic [WIDTH-1:0] par_out,
    input logic [WIDTH-1:0] chain_flat,
    input logic [WIDTH-1:0] lat_flat
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (chain_flat == '0 && (latch_en || lat_flat == '0)));

    assert_frozen_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |=> $stable(chain_flat));

    assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> lat_flat == chain_flat);

    assert_hold_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (latch_en || $stable(lat_flat)));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        localparam int unsigned B = k * DEPTH;

        assert_fwd_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (chip_sel && shift_dir) |=>
                (chain_flat[B] == $past(ser_in[k]) &&
                 chain_flat[B+1 +: DEPTH-1] == $past(chain_flat[B +: DEPTH-1])));

        assert_rev_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (chip_sel && !shift_dir) |=>
                (chain_flat[B+DEPTH-1] == $past(ser_in[k]) &&
                 chain_flat[B +: DEPTH-1] == $past(chain_flat[B+1 +: DEPTH-1])));

        assert_tap_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            shift_dir |-> ser_out[k] == chain_flat[B+DEPTH-1]);

        assert_tap_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !shift_dir |-> ser_out[k] == chain_flat[B]);

        assert_blank_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            blank[k] |-> par_out[B +: DEPTH] == {DEPTH{invert}});

        assert_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !blank[k] |-> par_out[B +: DEPTH] == (lat_flat[B +: DEPTH] ^ {DEPTH{invert}}));
    end

endmodule

bind quad_s2p_driver quad_s2p_driver_chk #(
    .LANES(LANES),
    .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .shift_dir (shift_dir),
    .latch_en  (latch_en),
    .invert    (invert),
    .blank     (blank),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .par_out   (par_out),
    .chain_flat(chain_flat),
    .lat_flat  (lat_flat)
);

// File: tb/quad_s2p_driver_bench.sv
// Bench: behavioural reference model compared with the outputs on every cycle.
module quad_s2p_driver_bench;

    localparam int LANES = 4;
    localparam int DEPTH = 8;
    localparam int W     = LANES * DEPTH;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           chip_sel = 1'b0;
    logic           shift_dir = 1'b1;
    logic           latch_en = 1'b0;
    logic           invert = 1'b0;
    logic [LANES-1:0] blank = '0;
    logic [LANES-1:0] ser_in = '0;
    logic [LANES-1:0] ser_out;
    logic [W-1:0]   par_out;

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";

    bit m_ch  [LANES][DEPTH];
    bit m_hold[LANES][DEPTH];

    quad_s2p_driver u_quad_s2p_driver (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (chip_sel),
        .shift_dir(shift_dir),
        .latch_en (latch_en),
        .invert   (invert),
        .blank    (blank),
        .ser_in   (ser_in),
        .ser_out  (ser_out),
        .par_out  (par_out)
    );

    always #4 clk = ~clk;

    // Reference model: updated on each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LANES; k++)
                for (int s = 0; s < DEPTH; s++) begin
                    m_ch[k][s] = 1'b0;
                    m_hold[k][s] = 1'b0;
                end
        end else begin
            if (chip_sel) begin
                for (int k = 0; k < LANES; k++) begin
                    if (shift_dir) begin
                        for (int s = DEPTH-1; s > 0; s--) m_ch[k][s] = m_ch[k][s-1];
                        m_ch[k][0] = ser_in[k];
                    end else begin
                        for (int s = 0; s < DEPTH-1; s++) m_ch[k][s] = m_ch[k][s+1];
                        m_ch[k][DEPTH-1] = ser_in[k];
                    end
                end
            end
            if (latch_en)
                for (int k = 0; k < LANES; k++)
                    for (int s = 0; s < DEPTH; s++) m_hold[k][s] = m_ch[k][s];
        end
    end

    function automatic logic [W-1:0] exp_par();
        logic [W-1:0] e;
        for (int k = 0; k < LANES; k++)
            for (int s = 0; s < DEPTH; s++) begin
                bit v;
                v = latch_en ? m_ch[k][s] : m_hold[k][s];
                if (blank[k]) v = 1'b0;
                e[k*DEPTH + s] = v ^ invert;
            end
        return e;
    endfunction

    function automatic logic [LANES-1:0] exp_sout();
        logic [LANES-1:0] e;
        for (int k = 0; k < LANES; k++)
            e[k] = shift_dir ? m_ch[k][DEPTH-1] : m_ch[k][0];
        return e;
    endfunction

    // Compare at the falling edge, half a cycle after the state settled.
    task automatic tick();
        logic [W-1:0]     ep;
        logic [LANES-1:0] es;
        @(negedge clk);
        ep = exp_par();
        es = exp_sout();
        compared++;
        if (par_out !== ep) begin
            mismatched++;
            $display("FAIL %s par_out actual=%h expected=%h", cur_req, par_out, ep);
        end
        compared++;
        if (ser_out !== es) begin
            mismatched++;
            $display("FAIL %s ser_out actual=%b expected=%b", cur_req, ser_out, es);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            ser_in = 4'($urandom);
            tick();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stimulus
        // R1: reset clears everything even with the chip selected and the latch open.
        @(posedge clk);
        cur_req = "R1";
        chip_sel = 1'b1; latch_en = 1'b1;
        for (int i = 0; i < 3; i++) begin ser_in = 4'hF; tick(); end
        rst_n = 1'b1;

        // R2: independent random streams on the four lanes.
        cur_req = "R2";
        run(12);

        // R3: a single one walks forward through lane 0 and leaves at the cascade output.
        cur_req = "R3";
        shift_dir = 1'b1;
        ser_in = 4'b0001; tick();
        for (int i = 0; i < 10; i++) begin ser_in = 4'b0000; tick(); end
        run(8);

        // R4: reverse shifting, including a one walking through lane 3.
        cur_req = "R4";
        shift_dir = 1'b0;
        ser_in = 4'b1000; tick();
        for (int i = 0; i < 10; i++) begin ser_in = 4'b0000; tick(); end
        run(10);

        // R5: chip deselected, the chains freeze despite changing inputs.
        cur_req = "R5";
        chip_sel = 1'b0;
        run(6);
        chip_sel = 1'b1;

        // R6: latch open, outputs track the chains.
        cur_req = "R6";
        shift_dir = 1'b1;
        run(8);

        // R7: latch closed while both directions shift new data underneath.
        cur_req = "R7";
        latch_en = 1'b0;
        run(6);
        shift_dir = 1'b0;
        run(6);

        // R8: blanking each lane in turn over a held frame, then over a live one.
        cur_req = "R8";
        for (int k = 0; k < LANES; k++) begin
            blank = 4'(1 << k);
            run(2);
        end
        latch_en = 1'b1;
        blank = 4'b0101;
        run(3);

        // R9: inversion with and without blanking, latch open and closed.
        cur_req = "R9";
        invert = 1'b1;
        run(3);
        blank = 4'b0000;
        run(3);
        latch_en = 1'b0;
        blank = 4'b1010;
        run(4);
        latch_en = 1'b1;
        run(2);
        invert = 1'b0; blank = 4'b0000;

        // R10: a distinct pattern per lane and stage, checked bit by bit.
        cur_req = "R10";
        shift_dir = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            ser_in = {1'(i % 2), 1'(i % 3 == 0), 1'(i < 4), 1'(i == 5)};
            tick();
        end
        chip_sel = 1'b0;
        tick();
        chip_sel = 1'b1;

        // R1: reset in the middle of shifting with the latch closed.
        cur_req = "R1";
        latch_en = 1'b0;
        run(4);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        ser_in = 4'b0000; chip_sel = 1'b0;
        tick();
        chip_sel = 1'b1;
        run(6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule